// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits between a processor's I/O port interface and a downstream configuration bus master. Software first writes a 32-bit word to an address port. That word holds an enable flag, a bus number, a device number, a function number, a dword register index and a cycle type. Software then reads or writes a data port. When the enable flag is set, the data-port access becomes one configuration request. The request carries the decoded target fields, the processor's byte enables and the write data. The processor is stalled until the downstream side completes it.

Any I/O access that the block does not claim goes out unchanged on a plain I/O forwarding port. This covers three cases: any other port address, a data-port access while the enable flag is clear, and an address-port access narrower than a full dword. A configuration read that the downstream side aborts, or that gets no answer within a bounded number of cycles, returns all ones to the processor.

Top module: `cfg_mech_bridge`

## Requirements
- R1: After reset the enable flag and all stored address bits are zero, and cpuReady, cfgReq and ioReq are all low.
- R2: A full access (cpuBe = 4'b1111) to port 16'h0CF8 is handled inside the block with no downstream request. A write stores the word. A read returns the stored word with bits 30..24 forced to zero.
- R3: An access to port 16'h0CF8 with any byte enable clear is forwarded on the I/O port, and the stored address word is left unchanged.
- R4: An access to port 16'h0CFC while bit 31 of the stored word is 0 is forwarded on the I/O port and raises no cfgReq.
- R5: An access to port 16'h0CFC while bit 31 is 1 raises exactly one cfgReq. The request carries cfgBus = bits 23..16, cfgDev = bits 15..11, cfgFunc = bits 10..8, cfgReg = bits 7..2 and cfgType = bits 1..0 of the stored word (00 type 0, 01 type 1), together with cpuWrite, cpuBe and cpuWdata. cfgReq stays high until cfgDone.
- R6: The cycle after cfgDone is sampled high, cpuReady is high. A read then returns cfgRdata.
- R7: A configuration read completed with cfgAbort high returns 32'hFFFF_FFFF.
- R8: If cfgDone does not arrive within TimeoutCycles cycles of cfgReq rising, cfgReq falls and the read returns 32'hFFFF_FFFF.
- R9: Accesses to any other port go to the I/O port with address, byte enables, direction and data unchanged, and a read returns ioRdata.
- R10: Each processor request gets exactly one single-cycle cpuReady pulse, and cfgReq and ioReq are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, held until cpuReady |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 16 | Dword-aligned I/O port address |
| cpuBe | input | 4 | Byte enables |
| cpuWdata | input | 32 | Write data |
| cpuReady | output | 1 | One-cycle completion pulse |
| cpuRdata | output | 32 | Read data, valid with cpuReady |
| cfgReq | output | 1 | Configuration request, held until completion |
| cfgWrite | output | 1 | Configuration direction |
| cfgBus | output | 8 | Target bus number |
| cfgDev | output | 5 | Target device number |
| cfgFunc | output | 3 | Target function number |
| cfgReg | output | 6 | Target dword register index |
| cfgType | output | 2 | Cycle type field |
| cfgBe | output | 4 | Configuration byte enables |
| cfgWdata | output | 32 | Configuration write data |
| cfgDone | input | 1 | Downstream completion |
| cfgAbort | input | 1 | Completion without a responding target |
| cfgRdata | input | 32 | Configuration read data |
| ioReq | output | 1 | Forwarded I/O request, held until ioReady |
| ioWrite | output | 1 | Forwarded direction |
| ioAddr | output | 16 | Forwarded port address |
| ioBe | output | 4 | Forwarded byte enables |
| ioWdata | output | 32 | Forwarded write data |
| ioReady | input | 1 | Forwarded access completion |
| ioRdata | input | 32 | Forwarded read data |

## Verification
The bench writes ones into the reserved field. A design that stored them, or forgot to mask them on read, shows them in the address-port readback. The bench also makes a narrow write to the address port. A design that decoded by port alone would claim that write and corrupt the stored word. The same write would be missing on the I/O port.

The bench runs data-port accesses with the enable flag clear. It also lets a target abort a read and lets another stay silent. A wrong design would then raise a configuration request when disabled, pass through garbage instead of all ones, or hang the processor forever. The bench checks the decoded field positions against a word with distinct bits in every field. It also checks that each access yields exactly one request and one ready pulse.

// File: rtl/cfg_mech_bridge_pkg.sv
package cfg_mech_bridge_pkg;
  localparam int DataW = 32;
  localparam int BeW = DataW / 8;
  localparam int PortW = 16;
  localparam logic [PortW-1:0] AddrPort = 16'h0CF8;
  localparam logic [PortW-1:0] DataPort = 16'h0CFC;

  typedef enum logic [1:0] {
    StIdle = 2'd0,
    StCfg  = 2'd1,
    StIo   = 2'd2,
    StResp = 2'd3
  } state_e;

  typedef struct packed {
    logic loadAddr;
    logic capAddr;
    logic capCfg;
    logic capIo;
    logic capOnes;
  } strobe_t;
endpackage

// File: rtl/cfg_mech_bridge_ctrl.sv
module cfg_mech_bridge_ctrl
  import cfg_mech_bridge_pkg::*;
#(
  parameter int TimeoutCycles = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuReq,
  input  logic             cpuWrite,
  input  logic [PortW-1:0] cpuAddr,
  input  logic [BeW-1:0]   cpuBe,
  input  logic             cfgEnable,
  input  logic             cfgDone,
  input  logic             cfgAbort,
  input  logic             ioReady,
  output strobe_t          strb,
  output logic             cfgReqO,
  output logic             ioReqO,
  output logic             cpuReadyO
);
  localparam int CntW = (TimeoutCycles > 1) ? $clog2(TimeoutCycles) : 1;
  localparam logic [CntW-1:0] CntLast = CntW'(TimeoutCycles - 1);

  state_e state, stateNext;
  logic [CntW-1:0] waitCnt;
  logic hitAddrFull, hitData;

  assign hitAddrFull = (cpuAddr == AddrPort) && (cpuBe == {BeW{1'b1}});
  assign hitData     = (cpuAddr == DataPort);

  always_comb begin
    strb = '0;
    stateNext = state;
    unique case (state)
      StIdle: begin
        if (cpuReq) begin
          if (hitAddrFull) begin
            strb.loadAddr = cpuWrite;
            strb.capAddr  = 1'b1;
            stateNext = StResp;
          end else if (hitData && cfgEnable) begin
            stateNext = StCfg;
          end else begin
            stateNext = StIo;
          end
        end
      end
      StCfg: begin
        if (cfgDone) begin
          strb.capCfg  = !cfgAbort;
          strb.capOnes = cfgAbort;
          stateNext = StResp;
        end else if (waitCnt == CntLast) begin
          strb.capOnes = 1'b1;
          stateNext = StResp;
        end
      end
      StIo: begin
        if (ioReady) begin
          strb.capIo = 1'b1;
          stateNext = StResp;
        end
      end
      StResp: stateNext = StIdle;
      default: stateNext = StIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= StIdle;
      waitCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == StCfg) waitCnt <= waitCnt + 1'b1;
      else                waitCnt <= '0;
    end
  end

  assign cfgReqO   = (state == StCfg);
  assign ioReqO    = (state == StIo);
  assign cpuReadyO = (state == StResp);
endmodule

// File: rtl/cfg_mech_bridge_dp.sv
module cfg_mech_bridge_dp
  import cfg_mech_bridge_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [DataW-1:0] cpuWdata,
  input  logic [DataW-1:0] cfgRdata,
  input  logic [DataW-1:0] ioRdata,
  output logic [DataW-1:0] addrWord,
  output logic [DataW-1:0] rdataO
);
  localparam logic [DataW-1:0] KeepMask = 32'h80FF_FFFF;

  logic [DataW-1:0] addrReg;

  assign addrWord = addrReg & KeepMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      rdataO  <= '0;
    end else begin
      if (strb.loadAddr) addrReg <= cpuWdata;
      if (strb.capAddr)       rdataO <= strb.loadAddr ? (cpuWdata & KeepMask) : addrWord;
      else if (strb.capCfg)   rdataO <= cfgRdata;
      else if (strb.capIo)    rdataO <= ioRdata;
      else if (strb.capOnes)  rdataO <= '1;
    end
  end
endmodule

// File: rtl/cfg_mech_bridge.sv
module cfg_mech_bridge
  import cfg_mech_bridge_pkg::*;
#(
  parameter int TimeoutCycles = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWrite,
  input  logic [15:0] cpuAddr,
  input  logic [3:0]  cpuBe,
  input  logic [31:0] cpuWdata,
  output logic        cpuReady,
  output logic [31:0] cpuRdata,
  output logic        cfgReq,
  output logic        cfgWrite,
  output logic [7:0]  cfgBus,
  output logic [4:0]  cfgDev,
  output logic [2:0]  cfgFunc,
  output logic [5:0]  cfgReg,
  output logic [1:0]  cfgType,
  output logic [3:0]  cfgBe,
  output logic [31:0] cfgWdata,
  input  logic        cfgDone,
  input  logic        cfgAbort,
  input  logic [31:0] cfgRdata,
  output logic        ioReq,
  output logic        ioWrite,
  output logic [15:0] ioAddr,
  output logic [3:0]  ioBe,
  output logic [31:0] ioWdata,
  input  logic        ioReady,
  input  logic [31:0] ioRdata
);
  strobe_t strb;
  logic [DataW-1:0] addrWord;

  cfg_mech_bridge_ctrl #(.TimeoutCycles(TimeoutCycles)) ctrl_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuBe(cpuBe), .cfgEnable(addrWord[31]),
    .cfgDone(cfgDone), .cfgAbort(cfgAbort), .ioReady(ioReady),
    .strb(strb), .cfgReqO(cfgReq), .ioReqO(ioReq), .cpuReadyO(cpuReady)
  );

  cfg_mech_bridge_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cpuWdata(cpuWdata),
    .cfgRdata(cfgRdata), .ioRdata(ioRdata),
    .addrWord(addrWord), .rdataO(cpuRdata)
  );

  assign cfgWrite = cpuWrite;
  assign cfgBus   = addrWord[23:16];
  assign cfgDev   = addrWord[15:11];
  assign cfgFunc  = addrWord[10:8];
  assign cfgReg   = addrWord[7:2];
  assign cfgType  = addrWord[1:0];
  assign cfgBe    = cpuBe;
  assign cfgWdata = cpuWdata;

  assign ioWrite = cpuWrite;
  assign ioAddr  = cpuAddr;
  assign ioBe    = cpuBe;
  assign ioWdata = cpuWdata;
endmodule

// File: rtl/cfg_mech_bridge_chk.sv
module cfg_mech_bridge_chk #(
  parameter int TimeoutCycles = 64
) (
  input logic        clk,
  input logic        rstN,
  input logic        cpuReq,
  input logic        cpuWrite,
  input logic [15:0] cpuAddr,
  input logic [3:0]  cpuBe,
  input logic        cpuReady,
  input logic [31:0] cpuRdata,
  input logic        cfgReq,
  input logic        cfgDone,
  input logic        ioReq
);
  int unsigned reqCycles;

  always_ff @(posedge clk) begin
    if (!rstN)       reqCycles <= 0;
    else if (cfgReq) reqCycles <= reqCycles + 1;
    else             reqCycles <= 0;
  end

  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgReq && ioReq));

  p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady);

  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReq && !cfgDone && reqCycles < TimeoutCycles - 1) |=> cfgReq);

  p_timeout_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReq && reqCycles == TimeoutCycles - 1) |=> !cfgReq);

  p_done_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReq && cfgDone) |=> cpuReady);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReady && !cpuWrite && cpuAddr == 16'h0CF8 && cpuBe == 4'hF) |-> cpuRdata[30:24] == 7'd0);

  p_cfg_only_data_r4: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq |-> (cpuReq && cpuAddr == 16'h0CFC));
endmodule

bind cfg_mech_bridge cfg_mech_bridge_chk #(.TimeoutCycles(TimeoutCycles)) chk_i (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite),
  .cpuAddr(cpuAddr), .cpuBe(cpuBe), .cpuReady(cpuReady), .cpuRdata(cpuRdata),
  .cfgReq(cfgReq), .cfgDone(cfgDone), .ioReq(ioReq)
);

// File: tb/cfg_mech_bridge_tb_top.sv
module cfg_mech_bridge_tb_top;
  localparam int Tmo = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 1'b0, cpuWrite = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [3:0]  cpuBe = '0;
  logic [31:0] cpuWdata = '0;
  logic cpuReady;
  logic [31:0] cpuRdata;
  logic cfgReq, cfgWrite;
  logic [7:0] cfgBus;
  logic [4:0] cfgDev;
  logic [2:0] cfgFunc;
  logic [5:0] cfgReg;
  logic [1:0] cfgType;
  logic [3:0] cfgBe;
  logic [31:0] cfgWdata;
  logic cfgDone = 1'b0, cfgAbort = 1'b0;
  logic [31:0] cfgRdata = '0;
  logic ioReq, ioWrite;
  logic [15:0] ioAddr;
  logic [3:0] ioBe;
  logic [31:0] ioWdata;
  logic ioReady = 1'b0;
  logic [31:0] ioRdata = '0;

  int checks = 0, errors = 0;
  int cycles = 0;
  int cfgMode = 0;
  int cfgWait = 0, ioWait = 0;
  int cfgRises = 0, ioRises = 0, cfgHigh = 0, cfgLastLen = 0;
  logic prevCfg = 1'b0, prevIo = 1'b0;
  logic [31:0] capTgt;
  logic [31:0] capCfgW;
  logic [15:0] capIoAddr;
  logic [3:0]  capIoBe, capCfgBe;
  logic        capIoW, capCfgWr;

  always #2 clk = ~clk;

  cfg_mech_bridge #(.TimeoutCycles(Tmo)) dut_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuBe(cpuBe), .cpuWdata(cpuWdata),
    .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .cfgReq(cfgReq), .cfgWrite(cfgWrite), .cfgBus(cfgBus), .cfgDev(cfgDev),
    .cfgFunc(cfgFunc), .cfgReg(cfgReg), .cfgType(cfgType), .cfgBe(cfgBe),
    .cfgWdata(cfgWdata), .cfgDone(cfgDone), .cfgAbort(cfgAbort),
    .cfgRdata(cfgRdata), .ioReq(ioReq), .ioWrite(ioWrite), .ioAddr(ioAddr),
    .ioBe(ioBe), .ioWdata(ioWdata), .ioReady(ioReady), .ioRdata(ioRdata)
  );

  // downstream responders and monitor, all at the falling edge
  always @(negedge clk) begin
    cycles++;
    if (cfgReq && !prevCfg) begin
      cfgRises++;
      capTgt   = {8'h0, cfgBus, cfgDev, cfgFunc, cfgReg, cfgType};
      capCfgW  = cfgWdata;
      capCfgBe = cfgBe;
      capCfgWr = cfgWrite;
    end
    if (ioReq && !prevIo) begin
      ioRises++;
      capIoAddr = ioAddr;
      capIoBe   = ioBe;
      capIoW    = ioWrite;
    end
    if (cfgReq) cfgHigh++;
    else if (prevCfg) begin cfgLastLen = cfgHigh; cfgHigh = 0; end
    prevCfg = cfgReq;
    prevIo  = ioReq;
    if (cfgReq) begin
      if (cfgMode != 2 && cfgWait == 1) begin
        cfgDone = 1'b1; cfgAbort = (cfgMode == 1);
      end else begin
        cfgDone = 1'b0; cfgAbort = 1'b0; cfgWait++;
      end
    end else begin
      cfgDone = 1'b0; cfgAbort = 1'b0; cfgWait = 0;
    end
    if (ioReq) begin
      if (ioWait == 2) ioReady = 1'b1;
      else begin ioReady = 1'b0; ioWait++; end
    end else begin
      ioReady = 1'b0; ioWait = 0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [15:0] addr, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd, output int readyLen);
    int waited;
    @(negedge clk);
    cpuReq = 1'b1; cpuWrite = wr; cpuAddr = addr; cpuBe = be; cpuWdata = wd;
    waited = 0;
    @(negedge clk);
    while (!cpuReady && waited < 500) begin @(negedge clk); waited++; end
    rd = cpuRdata;
    readyLen = cpuReady ? 1 : 0;
    cpuReq = 1'b0;
    @(negedge clk);
    if (cpuReady) readyLen++;
  endtask

  task automatic testReset();
    logic [31:0] rd; int rl;
    check("R1 cpuReady", {31'd0, cpuReady}, 32'd0);
    check("R1 cfgReq", {31'd0, cfgReq}, 32'd0);
    check("R1 ioReq", {31'd0, ioReq}, 32'd0);
    access(1'b0, 16'h0CF8, 4'hF, 32'd0, rd, rl);
    check("R1 address word", rd, 32'd0);
  endtask

  task automatic testAddrPort();
    logic [31:0] rd; int rl; int c0, i0;
    c0 = cfgRises; i0 = ioRises;
    access(1'b1, 16'h0CF8, 4'hF, 32'hFFAB_5AF9, rd, rl);
    access(1'b0, 16'h0CF8, 4'hF, 32'd0, rd, rl);
    check("R2 readback masked", rd, 32'h80AB_5AF9);
    check("R2 no downstream", cfgRises + ioRises - c0 - i0, 0);
    check("R10 single ready", rl, 1);
  endtask

  task automatic testNarrowAddr();
    logic [31:0] rd; int rl; int i0;
    i0 = ioRises;
    access(1'b1, 16'h0CF8, 4'h3, 32'h0000_0000, rd, rl);
    check("R3 forwarded", ioRises - i0, 1);
    check("R3 io addr", {16'd0, capIoAddr}, 32'h0CF8);
    check("R3 io be", {28'd0, capIoBe}, 32'h3);
    access(1'b0, 16'h0CF8, 4'hF, 32'd0, rd, rl);
    check("R3 word unchanged", rd, 32'h80AB_5AF9);
  endtask

  task automatic testCfgRead();
    logic [31:0] rd; int rl; int c0;
    c0 = cfgRises; cfgMode = 0; cfgRdata = 32'h1234_5678;
    access(1'b0, 16'h0CFC, 4'hF, 32'd0, rd, rl);
    check("R5 one request", cfgRises - c0, 1);
    check("R5 fields", capTgt, 32'h00AB_5AF9);
    check("R5 bus", {24'd0, capTgt[23:16]}, 32'hAB);
    check("R5 dev", {27'd0, capTgt[15:11]}, 32'h0B);
    check("R5 func", {29'd0, capTgt[10:8]}, 32'h2);
    check("R5 reg", {26'd0, capTgt[7:2]}, 32'h3E);
    check("R5 type", {30'd0, capTgt[1:0]}, 32'h1);
    check("R6 read data", rd, 32'h1234_5678);
    check("R10 single ready cfg", rl, 1);
  endtask

  task automatic testCfgWrite();
    logic [31:0] rd; int rl;
    cfgMode = 0;
    access(1'b1, 16'h0CFC, 4'b0100, 32'hA5C3_0F11, rd, rl);
    check("R5 write dir", {31'd0, capCfgWr}, 32'd1);
    check("R5 write be", {28'd0, capCfgBe}, 32'h4);
    check("R5 write data", capCfgW, 32'hA5C3_0F11);
  endtask

  task automatic testAbort();
    logic [31:0] rd; int rl;
    cfgMode = 1; cfgRdata = 32'h0BAD_0BAD;
    access(1'b0, 16'h0CFC, 4'hF, 32'd0, rd, rl);
    check("R7 abort ones", rd, 32'hFFFF_FFFF);
    cfgMode = 0;
  endtask

  task automatic testTimeout();
    logic [31:0] rd; int rl;
    cfgMode = 2; cfgRdata = 32'h0;
    access(1'b0, 16'h0CFC, 4'hF, 32'd0, rd, rl);
    check("R8 timeout ones", rd, 32'hFFFF_FFFF);
    check("R8 request length", cfgLastLen, Tmo);
    check("R10 single ready timeout", rl, 1);
    cfgMode = 0;
  endtask

  task automatic testDisabled();
    logic [31:0] rd; int rl; int c0, i0;
    access(1'b1, 16'h0CF8, 4'hF, 32'h0000_1234, rd, rl);
    c0 = cfgRises; i0 = ioRises; ioRdata = 32'h5566_7788;
    access(1'b0, 16'h0CFC, 4'hF, 32'd0, rd, rl);
    check("R4 no cfg request", cfgRises - c0, 0);
    check("R4 forwarded", ioRises - i0, 1);
    check("R4 io addr", {16'd0, capIoAddr}, 32'h0CFC);
    check("R4 io data", rd, 32'h5566_7788);
  endtask

  task automatic testOtherPort();
    logic [31:0] rd; int rl; int c0;
    c0 = cfgRises; ioRdata = 32'hCAFE_F00D;
    access(1'b0, 16'h0080, 4'b0010, 32'd0, rd, rl);
    check("R9 io read", rd, 32'hCAFE_F00D);
    check("R9 io addr", {16'd0, capIoAddr}, 32'h0080);
    check("R9 io be", {28'd0, capIoBe}, 32'h2);
    check("R9 io dir", {31'd0, capIoW}, 32'd0);
    check("R9 no cfg", cfgRises - c0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAddrPort();
    testNarrowAddr();
    testCfgRead();
    testCfgWrite();
    testAbort();
    testTimeout();
    testDisabled();
    testOtherPort();
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule